// File: doc/BRIEF.md
# Two-Key Sequence Lock Controller

This block is a clocked Moore controller for a lock worked by two push keys, here called key A and key B. On every rising clock edge the controller samples both keys as one two-bit pattern. The lock opens only when it sees three patterns in a row: key A alone, then key B alone, then key B alone again. Any other pattern in the middle of an attempt drops the controller back to its idle state. A pattern with both keys pressed or neither pressed counts as wrong, so each step needs exactly one key.

The `open` output follows the state register alone. It goes high in the clock cycle after the third correct pattern is sampled. While open, a fresh key-A-alone pattern starts a new attempt at once. Any other pattern returns the lock to idle.

The state can be stored in three encodings, picked by a parameter: plain binary, a Gray-style order, or one-hot. All three give the same behaviour at the ports. The reset input is asynchronous and active low. A small synchronizer inside the block makes its release synchronous to the clock.

Top module: `seq_lock`

## Requirements
- R1: While `rst_n` is low, and for two rising clock edges after it goes high, the controller is held in idle. `unlock` is low throughout, and key patterns applied in that window have no effect.
- R2: In idle, the pattern {key_a,key_b}=10 moves to the one-correct state. The patterns 00, 01 and 11 leave the controller in idle.
- R3: In the one-correct state, pattern 01 moves to the two-correct state. Patterns 00, 10 and 11 return to idle.
- R4: In the two-correct state, pattern 01 moves to the open state. Patterns 00, 10 and 11 return to idle.
- R5: `unlock` is high exactly while the controller is in the open state. It rises in the cycle after the third correct pattern is sampled. It is never high for two cycles in a row.
- R6: In the open state, pattern 10 moves straight to the one-correct state, so back-to-back attempts need no idle cycle. Patterns 00, 01 and 11 return to idle.
- R7: The parameter `ENC` selects the state codes. ENC_BIN uses idle=00, one=01, two=10, open=11. ENC_GRAY uses idle=00, one=01, two=11, open=10. ENC_ONEHOT uses idle=1000, one=0100, two=0010, open=0001. All three give identical `unlock` waveforms for any key sequence.
- R8: Pulling `rst_n` low clears `unlock` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; keys are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| key_a | input | 1 | First key, active high |
| key_b | input | 1 | Second key, active high |
| unlock | output | 1 | High while the lock is open |

## Verification
The bound checker tests every transition on every cycle: idle holds on wrong patterns, each correct pattern advances one step, each wrong pattern in an attempt falls back to idle, and the open state is either followed by a restart or by idle. It also checks that `unlock` never stays high for two cycles and stays low while the synchronized reset is active. Only the bench scenarios can show that the three encodings give the same waveform, since each build holds a single encoding. The same goes for the immediate clear on an asynchronous reset and for back-to-back openings, where a fresh attempt starts at once.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;

  // Abstract position within an unlock attempt.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ONE  = 2'd1,
    ST_TWO  = 2'd2,
    ST_OPEN = 2'd3
  } lock_step_e;

  // Physical state encoding choice.
  typedef enum logic [1:0] {
    ENC_BIN    = 2'd0,
    ENC_GRAY   = 2'd1,
    ENC_ONEHOT = 2'd2
  } lock_enc_e;

  // Key patterns, written as {key_a, key_b}.
  localparam logic [1:0] PAT_FIRST = 2'b10;
  localparam logic [1:0] PAT_NEXT  = 2'b01;

  function automatic int code_width(lock_enc_e enc);
    return (enc == ENC_ONEHOT) ? 4 : 2;
  endfunction

  // Code for a step, right-aligned in four bits.
  function automatic logic [3:0] step_code(lock_enc_e enc, lock_step_e s);
    logic [3:0] c;
    case (enc)
      ENC_GRAY:   c = {2'b00, s[1], s[1] ^ s[0]};
      ENC_ONEHOT: c = 4'b1000 >> s;
      default:    c = {2'b00, s};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/lock_rst_sync.sv
module lock_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  // Assert at once, release after STAGES rising edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/lock_state_codec.sv
module lock_state_codec
  import seq_lock_pkg::*;
#(
  parameter lock_enc_e ENC = ENC_BIN,
  localparam int SW = code_width(ENC)
) (
  input  logic [SW-1:0] code_in,
  input  lock_step_e    step_in,
  output lock_step_e    step_out,
  output logic          code_legal,
  output logic [SW-1:0] code_out
);

  logic [3:0] code_wide;

  assign code_wide = step_code(ENC, step_in);
  assign code_out  = code_wide[SW-1:0];

  generate
    if (ENC == ENC_ONEHOT) begin : g_hot
      always_comb begin
        code_legal = 1'b1;
        case (code_in)
          4'b1000: step_out = ST_IDLE;
          4'b0100: step_out = ST_ONE;
          4'b0010: step_out = ST_TWO;
          4'b0001: step_out = ST_OPEN;
          default: begin
            step_out   = ST_IDLE;
            code_legal = 1'b0;
          end
        endcase
      end
    end else if (ENC == ENC_GRAY) begin : g_gray
      assign step_out   = lock_step_e'({code_in[1], code_in[1] ^ code_in[0]});
      assign code_legal = 1'b1;
    end else begin : g_bin
      assign step_out   = lock_step_e'(code_in);
      assign code_legal = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/lock_step_logic.sv
module lock_step_logic
  import seq_lock_pkg::*;
(
  input  lock_step_e cur_step,
  input  logic       cur_legal,
  input  logic       key_a,
  input  logic       key_b,
  output lock_step_e nxt_step,
  output logic       is_open
);

  logic [1:0] pat;

  assign pat = {key_a, key_b};

  always_comb begin
    nxt_step = ST_IDLE;
    if (cur_legal) begin
      case (cur_step)
        ST_IDLE: nxt_step = (pat == PAT_FIRST) ? ST_ONE  : ST_IDLE;
        ST_ONE:  nxt_step = (pat == PAT_NEXT)  ? ST_TWO  : ST_IDLE;
        ST_TWO:  nxt_step = (pat == PAT_NEXT)  ? ST_OPEN : ST_IDLE;
        ST_OPEN: nxt_step = (pat == PAT_FIRST) ? ST_ONE  : ST_IDLE;
        default: nxt_step = ST_IDLE;
      endcase
    end
  end

  // An illegal code is treated as idle and never reads as open.
  assign is_open = cur_legal && (cur_step == ST_OPEN);

endmodule

// File: rtl/seq_lock.sv
module seq_lock
  import seq_lock_pkg::*;
#(
  parameter lock_enc_e ENC         = ENC_BIN,
  parameter int        SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_a,
  input  logic key_b,
  output logic unlock
);

  localparam int         SW        = code_width(ENC);
  localparam logic [3:0] IDLE_WIDE = step_code(ENC, ST_IDLE);
  localparam logic [SW-1:0] IDLE_CODE = IDLE_WIDE[SW-1:0];

  logic          rst_sync_n;
  logic [SW-1:0] state_q;
  logic [SW-1:0] state_d;
  lock_step_e    cur_step;
  lock_step_e    nxt_step;
  logic          code_ok;
  logic          open_flag;
  logic          state_en;

  lock_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lock_state_codec #(.ENC(ENC)) u_codec (
    .code_in    (state_q),
    .step_in    (nxt_step),
    .step_out   (cur_step),
    .code_legal (code_ok),
    .code_out   (state_d)
  );

  lock_step_logic u_step (
    .cur_step  (cur_step),
    .cur_legal (code_ok),
    .key_a     (key_a),
    .key_b     (key_b),
    .nxt_step  (nxt_step),
    .is_open   (open_flag)
  );

  // Update only when the code would change.
  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= IDLE_CODE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign unlock = open_flag;

endmodule

// File: rtl/seq_lock_checker.sv
module seq_lock_checker
  import seq_lock_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rst_sync_n,
  input logic       key_a,
  input logic       key_b,
  input lock_step_e cur_step,
  input logic       unlock
);

  logic [1:0] pat;
  assign pat = {key_a, key_b};

  assert_held_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync_n |-> (!unlock && cur_step == ST_IDLE));

  assert_idle_start_R2: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (cur_step == ST_IDLE && pat == 2'b10) |=> cur_step == ST_ONE);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (cur_step == ST_IDLE && pat != 2'b10) |=> cur_step == ST_IDLE);

  assert_one_step_R3: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (cur_step == ST_ONE) |=> (cur_step == ($past(pat) == 2'b01 ? ST_TWO : ST_IDLE)));

  assert_two_step_R4: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (cur_step == ST_TWO) |=> (cur_step == ($past(pat) == 2'b01 ? ST_OPEN : ST_IDLE)));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    unlock |=> !unlock);

  assert_open_rises_R5: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (cur_step == ST_TWO && pat == 2'b01) |=> unlock);

  assert_open_restart_R6: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (cur_step == ST_OPEN) |=> (cur_step == ($past(pat) == 2'b10 ? ST_ONE : ST_IDLE)));

endmodule

bind seq_lock seq_lock_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .key_a      (key_a),
  .key_b      (key_b),
  .cur_step   (cur_step),
  .unlock     (unlock)
);

// File: tb/seq_lock_test.sv
module seq_lock_test;
  import seq_lock_pkg::*;

  localparam time CLK_PERIOD = 10ns;

  logic clk;
  logic rst_n;
  logic key_a;
  logic key_b;
  logic unl_bin;
  logic unl_gray;
  logic unl_hot;

  int unsigned n_vec;
  int unsigned n_bad;
  int          model;   // 0 idle, 1 one, 2 two, 3 open

  seq_lock #(.ENC(ENC_BIN))    uut      (.clk(clk), .rst_n(rst_n), .key_a(key_a), .key_b(key_b), .unlock(unl_bin));
  seq_lock #(.ENC(ENC_GRAY))   uut_gray (.clk(clk), .rst_n(rst_n), .key_a(key_a), .key_b(key_b), .unlock(unl_gray));
  seq_lock #(.ENC(ENC_ONEHOT)) uut_hot  (.clk(clk), .rst_n(rst_n), .key_a(key_a), .key_b(key_b), .unlock(unl_hot));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ref_next(int s, logic [1:0] p);
    case (s)
      0: return (p == 2'b10) ? 1 : 0;
      1: return (p == 2'b01) ? 2 : 0;
      2: return (p == 2'b01) ? 3 : 0;
      default: return (p == 2'b10) ? 1 : 0;
    endcase
  endfunction

  function automatic string ref_tag(int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic check_all(string tag, logic exp);
    n_vec++;
    if (unl_bin !== exp) begin
      n_bad++;
      $display("FAIL %s/R5 bin unlock=%b expected %b", tag, unl_bin, exp);
    end
    n_vec++;
    if (unl_gray !== exp) begin
      n_bad++;
      $display("FAIL %s/R7 gray unlock=%b expected %b", tag, unl_gray, exp);
    end
    n_vec++;
    if (unl_hot !== exp) begin
      n_bad++;
      $display("FAIL %s/R7 onehot unlock=%b expected %b", tag, unl_hot, exp);
    end
  endtask

  // Drive at negedge, sample edge, check at next negedge.
  task automatic step(logic [1:0] p);
    string tag;
    tag = ref_tag(model);
    key_a = p[1];
    key_b = p[0];
    @(posedge clk);
    model = ref_next(model, p);
    @(negedge clk);
    check_all(tag, model == 3);
  endtask

  task automatic do_reset();
    key_a = 1'b0;
    key_b = 1'b0;
    rst_n = 1'b0;
    model = 0;
    repeat (3) @(negedge clk);
    check_all("R1", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1", 1'b0);
    // Pattern inside the release window must be ignored (R1).
    key_a = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_all("R1", 1'b0);
    key_a = 1'b0;
    @(negedge clk);
    model = 0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    n_vec = 0;
    n_bad = 0;
    seed  = 32'd20240611;
    void'($urandom(seed));
    @(negedge clk);
    do_reset();
    // R1: after the window the lock needs a full three-step sequence.
    step(2'b01); step(2'b01);
    // R2: idle ignores 00, 01, 11.
    step(2'b00); step(2'b11); step(2'b01);
    // Plain correct sequence (R5).
    step(2'b10); step(2'b01); step(2'b01);
    step(2'b00);
    // 11 inserted mid attempt (R3).
    step(2'b10); step(2'b11); step(2'b01); step(2'b01);
    // 00 inserted mid attempt (R4).
    step(2'b10); step(2'b01); step(2'b00); step(2'b01);
    // Repeated first key (R3).
    step(2'b10); step(2'b10); step(2'b01); step(2'b01);
    // Back-to-back openings (R6).
    step(2'b10); step(2'b01); step(2'b01);
    step(2'b10); step(2'b01); step(2'b01);
    step(2'b10); step(2'b01); step(2'b01);
    // Open then wrong pattern (R6).
    step(2'b11);
    // Asynchronous clear while open (R8).
    step(2'b10); step(2'b01); step(2'b01);
    #(CLK_PERIOD/4) rst_n = 1'b0;
    #1;
    check_all("R8", 1'b0);
    @(negedge clk);
    do_reset();
    // Random traffic, biased toward correct keys.
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] p;
      if (($urandom % 10) < 6) begin
        p = (model == 0 || model == 3) ? 2'b10 : 2'b01;
      end else begin
        p = 2'($urandom % 4);
      end
      step(p);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule